// File: doc/BRIEF.md
# RC Failsafe and Arm Controller

This block sits behind a radio-control frame parser. It watches the arm-switch channel value and the strobe that marks each valid channel frame, along with a one-cycle pulse per millisecond. From these it decides three things. The first is whether the radio link is alive. The second is when an arm sequence should begin. The third is when the system must be disarmed, either because the pilot flipped the switch off or because frames stopped arriving.

The arm switch level is the arm channel's raw value compared against a threshold. The value is sampled only when a frame is valid. The switch only counts while the link is alive. The block reacts to edges of that combined level, not to the level itself. Holding the switch on therefore requests exactly one arm start.

The loss-of-signal timer stays inert until the first valid frame. A system used without any radio attached is never disarmed by it. The arm-hold delay and the motor control live elsewhere. `armed` and `arm_permit` report their state back into this block.

Top module: `rc_arm_guard`

## Requirements
- R1: After reset, `arm_start`, `arm_cancel`, `disarm` and `rc_alive` are all low.
- R2: `rc_alive` stays low until the first `frame_valid` strobe, however many millisecond ticks pass. No `disarm` is produced before that frame, even while `armed` is high.
- R3: In the cycle after a `frame_valid` strobe, `rc_alive` is high. It remains high while at most 300 ticks have arrived since the last frame. It drops on the 301st tick.
- R4: The elapsed-time count saturates. After an outage of thousands of ticks, `rc_alive` stays low until a new frame arrives.
- R5: The switch is on when the `arm_ch` value latched at a valid frame is strictly greater than 1750. A value of exactly 1750 is off, and 1751 is on.
- R6: A rising edge of the effective level (switch on AND `rc_alive`) gives a one-cycle `arm_start` pulse one cycle after the edge. The pulse is given only if `armed` is low and `arm_permit` is high in that cycle.
- R7: A falling edge of the effective level gives a one-cycle `arm_cancel` pulse one cycle after the edge. If `armed` is high in that cycle, it also gives `disarm`. `arm_start` and `arm_cancel` never coincide.
- R8: Once a frame has been seen and the link is lost, `disarm` stays high in every cycle in which `armed` is high, starting one cycle after `rc_alive` drops.
- R9: A switch already on before any frame is not a rising edge. The first valid frame that carries it on produces the `arm_start`.
- R10: Further frames with the switch held on produce no further `arm_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per elapsed millisecond |
| frame_valid | input | 1 | One-cycle strobe when a valid channel frame has been decoded |
| arm_ch | input | CH_W (11) | Raw value of the arm-switch channel (channel index 4) from the parser |
| armed | input | 1 | System is currently armed |
| arm_permit | input | 1 | External conditions allow an arm start |
| arm_start | output | 1 | Pulse: begin the arm-hold sequence |
| arm_cancel | output | 1 | Pulse: cancel any pending arm request |
| disarm | output | 1 | Disarm command |
| rc_alive | output | 1 | A frame has been seen and the link is within its timeout |

## Verification
The bench probes the timeout boundary one tick at a time. A design with an off-by-one compare would drop `rc_alive` on the 300th tick or keep it through the 301st. It runs an outage far longer than the counter's range. A wrapping counter would bring `rc_alive` back falsely. It also holds `armed` high with the switch on before any frame. A timer that is not inert would disarm there, and a level-driven design would request an arm start. Further cases cover the 1750/1751 threshold, repeated on-frames (a level-triggered design would pulse `arm_start` again), and disarm gating by `armed` and `arm_permit`.

// File: rtl/rc_arm_guard.sv
module rc_arm_guard #(
  parameter int CH_W       = 11,
  parameter int ARM_THRESH = 1750,
  parameter int TIMEOUT_MS = 300
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ms_tick,
  input  logic            frame_valid,
  input  logic [CH_W-1:0] arm_ch,
  input  logic            armed,
  input  logic            arm_permit,
  output logic            arm_start,
  output logic            arm_cancel,
  output logic            disarm,
  output logic            rc_alive
);

  localparam int CNT_W = $clog2(TIMEOUT_MS + 2);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_MS);
  localparam logic [CNT_W-1:0] SAT   = CNT_W'(TIMEOUT_MS + 1);
  localparam logic [CH_W-1:0]  THR   = CH_W'(ARM_THRESH);

  logic             seen;
  logic             sw_on;
  logic             eff_prev;
  logic [CNT_W-1:0] elapsed;
  logic             eff, rise, fall, lost;

  assign rc_alive = seen && (elapsed <= LIMIT);
  assign lost     = seen && !rc_alive;
  assign eff      = sw_on && rc_alive;
  assign rise     = eff && !eff_prev;
  assign fall     = !eff && eff_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      sw_on   <= 1'b0;
      elapsed <= '0;
    end else if (frame_valid) begin
      seen    <= 1'b1;
      sw_on   <= (arm_ch > THR);
      elapsed <= '0;
    end else if (ms_tick && seen && elapsed != SAT) begin
      elapsed <= elapsed + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_prev   <= 1'b0;
      arm_start  <= 1'b0;
      arm_cancel <= 1'b0;
      disarm     <= 1'b0;
    end else begin
      eff_prev   <= eff;
      arm_start  <= rise && !armed && arm_permit;
      arm_cancel <= fall;
      disarm     <= armed && (fall || lost);
    end
  end

endmodule

// File: rtl/rc_arm_guard_chk.sv
module rc_arm_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic ms_tick,
  input logic frame_valid,
  input logic armed,
  input logic arm_permit,
  input logic arm_start,
  input logic arm_cancel,
  input logic disarm,
  input logic rc_alive
);

  logic seen_c;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_c <= 1'b0;
    else if (frame_valid) seen_c <= 1'b1;
  end

  assert_no_alive_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_c |-> !rc_alive);

  assert_no_disarm_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_c |-> !disarm);

  assert_frame_alive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> rc_alive);

  assert_drop_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rc_alive) |-> $past(ms_tick));

  assert_start_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arm_start |-> $past(!armed && arm_permit));

  assert_disarm_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disarm |-> $past(armed));

  assert_start_cancel_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(arm_start && arm_cancel));

endmodule

bind rc_arm_guard rc_arm_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .frame_valid(frame_valid),
  .armed(armed), .arm_permit(arm_permit), .arm_start(arm_start),
  .arm_cancel(arm_cancel), .disarm(disarm), .rc_alive(rc_alive)
);

// File: tb/rc_arm_guard_tb.sv
module rc_arm_guard_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, fv = 1'b0, armed = 1'b0, permit = 1'b0;
  logic [10:0] chv = '0;
  logic        arm_start, arm_cancel, disarm, rc_alive;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { logic [3:0] v; string req; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  rc_arm_guard u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(tick), .frame_valid(fv), .arm_ch(chv),
    .armed(armed), .arm_permit(permit), .arm_start(arm_start),
    .arm_cancel(arm_cancel), .disarm(disarm), .rc_alive(rc_alive)
  );

  // expected order: {rc_alive, arm_start, arm_cancel, disarm}
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      logic [3:0] act;
      e = q.pop_front();
      act = {rc_alive, arm_start, arm_cancel, disarm};
      checks++;
      if (act !== e.v) begin
        fails++;
        $display("FAIL %s: got alive/start/cancel/disarm=%b expected %b", e.req, act, e.v);
      end
    end
  end

  task automatic cyc(input logic f, input logic [10:0] c, input logic t,
                     input logic a, input logic p, input logic [3:0] e, input string r);
    @(negedge clk);
    fv = f; chv = c; tick = t; armed = a; permit = p;
    q.push_back('{e, r});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 4'b0000, "R1 reset state");

    // R2 / R9: switch on, armed, ticks running, no frame yet
    for (int i = 0; i < 400; i++)
      cyc(0, 11'd2000, 1, 1, 1, 4'b0000, "R2 R9 no frame yet");

    // R5 boundary: 1750 is off
    cyc(1, 11'd1750, 0, 0, 1, 4'b1000, "R3 alive after frame");
    cyc(0, 11'd1750, 0, 0, 1, 4'b1000, "R5 1750 is off");
    // R5 / R6 / R9: 1751 is on -> arm_start
    cyc(1, 11'd1751, 0, 0, 1, 4'b1000, "R5 frame 1751");
    cyc(0, 11'd1751, 0, 0, 1, 4'b1100, "R6 arm_start on rising edge");
    cyc(0, 11'd1751, 0, 0, 1, 4'b1000, "R6 single pulse");
    // R10: held on
    cyc(1, 11'd1900, 0, 0, 1, 4'b1000, "R10 repeat frame");
    cyc(0, 11'd1900, 0, 0, 1, 4'b1000, "R10 no second start");
    // R7: off while armed
    cyc(1, 11'd1000, 0, 0, 1, 4'b1000, "R7 off frame");
    cyc(0, 11'd1000, 0, 1, 1, 4'b1011, "R7 cancel and disarm");
    cyc(0, 11'd1000, 0, 0, 1, 4'b1000, "R7 pulses end");
    // R6: permit low blocks start
    cyc(1, 11'd1900, 0, 0, 0, 4'b1000, "R6 frame permit low");
    cyc(0, 11'd1900, 0, 0, 0, 4'b1000, "R6 start blocked by permit");
    // R7: off while disarmed -> cancel only
    cyc(1, 11'd100, 0, 0, 1, 4'b1000, "R7 off frame disarmed");
    cyc(0, 11'd100, 0, 0, 1, 4'b1010, "R7 cancel without disarm");
    // R6: armed blocks start
    cyc(1, 11'd1900, 0, 1, 1, 4'b1000, "R6 frame while armed");
    cyc(0, 11'd1900, 0, 1, 1, 4'b1000, "R6 start blocked by armed");

    // R3 / R8: timeout boundary while armed
    for (int j = 1; j <= 300; j++)
      cyc(0, 11'd1900, 1, 1, 1, 4'b1000, "R3 alive within 300 ticks");
    cyc(0, 11'd1900, 1, 1, 1, 4'b0000, "R3 drop on tick 301");
    cyc(0, 11'd1900, 1, 1, 1, 4'b0011, "R8 disarm and cancel on loss");
    for (int j = 0; j < 3; j++)
      cyc(0, 11'd1900, 1, 1, 1, 4'b0001, "R8 disarm held while armed and lost");
    cyc(0, 11'd1900, 1, 0, 1, 4'b0000, "R8 disarm clears when disarmed");

    // R4: long outage, counter must not wrap
    for (int j = 0; j < 5000; j++)
      cyc(0, 11'd1900, 1, 0, 1, 4'b0000, "R4 saturated outage");

    // recovery: first frame after outage with switch on
    cyc(1, 11'd1900, 0, 0, 1, 4'b1000, "R3 alive again");
    cyc(0, 11'd1900, 0, 0, 1, 4'b1100, "R6 start after recovery");
    cyc(0, 11'd1900, 0, 0, 1, 4'b1000, "R6 single pulse after recovery");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule